// File: doc/BRIEF.md
# Cluster Directory Coherence Controller

This block sits in the network interface of one cluster. It keeps a small directory covering the lines whose home is this cluster's memory and that some cluster holds in its cache. Each directory record stores a line address, a state bit and a vector with one bit per cluster. The state is either Shared, where any number of clusters may hold read copies, or Exclusive, where one cluster owns the line and may have modified it. Every incoming memory request is looked up in the directory. When other clusters must act first, the controller sends them messages. An invalidate goes to each other sharer before a write. A fetch goes to the owner of an Exclusive line that some other cluster wants. The request is granted only after every expected acknowledgement has arrived, and the record is then updated.

Only one request is in flight at a time. Invalidates go out one per cycle, in ascending cluster number. An eviction request removes the requester from the vector, and the record is released once the vector becomes empty. When the directory is full, a request that would need a new record is refused until a record is freed.

Top module: `dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and both `msg_valid` and `grant` are 0.
- R2: The request kind on `req_op` is 0 for read, 1 for write and 2 for evict. A read or write to an address with no record creates an Exclusive record owned by the requester, and is granted without any message.
- R3: A read to a Shared line adds the requester to the sharers and is granted without any message.
- R4: A read or write to an Exclusive line owned by another cluster sends exactly one fetch message (`msg_type` 1) to the owner. After the read, the line is Shared by the owner and the requester. After the write, the line is Exclusive to the requester. A write by the owner itself sends nothing.
- R5: A write to a Shared line sends an invalidate (`msg_type` 0) to every sharer except the writer. The line then becomes Exclusive to the writer. If the writer was the only sharer, nothing is sent.
- R6: The messages of one request leave one per cycle, in strictly ascending destination order. Each carries the request's address and the same type.
- R7: A request with messages is held, with `req_ready` 0 and no `grant`, until an acknowledgement has arrived from every destination. An acknowledgement from a cluster that was not messaged does not release it.
- R8: An evict removes the requester from the line's vector. A record whose vector becomes empty is freed, so the next access to that address is treated as a miss. An evict from a cluster that does not hold the line changes nothing.
- R9: When every record is in use, `req_ready` is 0 for a read or write to an address with no record. An evict to such an address is still accepted.
- R10: `grant` is a one-cycle pulse. `req_ready` stays 0 from the cycle after acceptance until the request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_addr | input | AW | Line address |
| req_src | input | log2(NCL) | Requesting cluster |
| msg_valid | output | 1 | Outgoing coherence message present |
| msg_type | output | 1 | 0 invalidate, 1 fetch dirty line |
| msg_dst | output | log2(NCL) | Destination cluster |
| msg_addr | output | AW | Line address of the message |
| ack_valid | input | 1 | Acknowledgement or returned line present |
| ack_src | input | log2(NCL) | Cluster that acknowledges |
| grant | output | 1 | Pulse: current request completed |

## Verification
The hardest case to reach is a request left waiting on partial acknowledgements, with the directory entry meanwhile in an intermediate state. The automatic responder in the bench acknowledges each message at once, so this case never arises under it. A directed test therefore builds a two-sharer line through the table, then issues a write from a third cluster and withholds the acknowledgements. It sends an acknowledgement from a cluster that was never messaged, then the two real acknowledgements one at a time, and watches `grant` and `req_ready` after each. Filling the directory to refuse a miss also takes deliberate setup: the table leaves two records live, and six more reads fill the rest.

// File: rtl/dir_ctrl.sv
module dir_ctrl #(
  parameter int NCL = 16,
  parameter int AW  = 16,
  parameter int ENT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_op,
  input  logic [AW-1:0]          req_addr,
  input  logic [$clog2(NCL)-1:0] req_src,
  output logic                   msg_valid,
  output logic                   msg_type,
  output logic [$clog2(NCL)-1:0] msg_dst,
  output logic [AW-1:0]          msg_addr,
  input  logic                   ack_valid,
  input  logic [$clog2(NCL)-1:0] ack_src,
  output logic                   grant
);
  localparam int CW = $clog2(NCL);
  localparam int IW = (ENT > 1) ? $clog2(ENT) : 1;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;

  logic          e_v    [ENT];
  logic          e_x    [ENT];
  logic [AW-1:0] e_addr [ENT];
  logic [NCL-1:0] e_vec [ENT];

  logic           busy, c_hit;
  logic [1:0]     c_op;
  logic [CW-1:0]  c_src;
  logic [IW-1:0]  c_idx;
  logic [NCL-1:0] send, pend, tgt, src_bit, c_bit, low_bit, ack_bit;
  logic           hit, full, fetch;
  logic [IW-1:0]  hidx, fidx;
  logic [NCL-1:0] hv;
  logic           hx;

  always_comb begin
    hit = 1'b0; hidx = '0; full = 1'b1; fidx = '0;
    for (int e = 0; e < ENT; e++)
      if (e_v[e] && e_addr[e] == req_addr && !hit) begin
        hit = 1'b1; hidx = IW'(e);
      end
    for (int e = ENT - 1; e >= 0; e--)
      if (!e_v[e]) begin
        full = 1'b0; fidx = IW'(e);
      end
  end

  assign hv      = e_vec[hidx];
  assign hx      = e_x[hidx];
  assign src_bit = NCL'(1) << req_src;
  assign c_bit   = NCL'(1) << c_src;
  assign ack_bit = ack_valid ? (NCL'(1) << ack_src) : '0;

  always_comb begin
    tgt = '0;
    if (hit) begin
      if (hx && (hv & src_bit) == '0 && req_op != OP_EV) tgt = hv;
      else if (!hx && req_op == OP_WR)                   tgt = hv & ~src_bit;
    end
  end

  assign req_ready = !busy && !(req_op != OP_EV && !hit && full);

  always_comb begin
    msg_dst = '0;
    for (int i = NCL - 1; i >= 0; i--)
      if (send[i]) msg_dst = CW'(i);
  end
  assign msg_valid = |send;
  assign low_bit   = msg_valid ? (NCL'(1) << msg_dst) : '0;

  wire done = busy && send == '0 && pend == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; grant <= 1'b0; send <= '0; pend <= '0;
      c_hit <= 1'b0; c_op <= '0; c_src <= '0; c_idx <= '0;
      msg_type <= 1'b0; msg_addr <= '0;
      for (int e = 0; e < ENT; e++) begin
        e_v[e] <= 1'b0; e_x[e] <= 1'b0; e_addr[e] <= '0; e_vec[e] <= '0;
      end
    end else begin
      grant <= 1'b0;
      if (req_valid && req_ready) begin
        busy     <= 1'b1;
        c_hit    <= hit;
        c_op     <= req_op;
        c_src    <= req_src;
        c_idx    <= hit ? hidx : fidx;
        msg_addr <= req_addr;
        msg_type <= hx;
        send     <= tgt;
        pend     <= tgt;
      end else if (busy) begin
        send <= send & ~low_bit;
        pend <= pend & ~ack_bit;
        if (done) begin
          busy  <= 1'b0;
          grant <= 1'b1;
          case (c_op)
            OP_WR: begin
              e_v[c_idx] <= 1'b1; e_addr[c_idx] <= msg_addr;
              e_x[c_idx] <= 1'b1; e_vec[c_idx] <= c_bit;
            end
            OP_EV: if (c_hit) begin
              e_vec[c_idx] <= e_vec[c_idx] & ~c_bit;
              if ((e_vec[c_idx] & ~c_bit) == '0) e_v[c_idx] <= 1'b0;
            end
            default: if (!c_hit) begin
              e_v[c_idx] <= 1'b1; e_addr[c_idx] <= msg_addr;
              e_x[c_idx] <= 1'b1; e_vec[c_idx] <= c_bit;
            end else if (!(e_x[c_idx] && (e_vec[c_idx] & c_bit) != '0)) begin
              e_x[c_idx]   <= 1'b0;
              e_vec[c_idx] <= e_vec[c_idx] | c_bit;
            end
          endcase
        end
      end
    end
  end

  assign fetch = msg_type;
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NCL = 16,
  parameter int AW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   msg_valid,
  input logic                   msg_type,
  input logic [$clog2(NCL)-1:0] msg_dst,
  input logic [AW-1:0]          msg_addr,
  input logic                   grant
);
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R10
  AST_HOLD_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready && !grant); // R7
  AST_ASCENDING_DST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && $past(msg_valid) |-> msg_dst > $past(msg_dst)); // R6
  AST_MSG_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && $past(msg_valid) |-> $stable(msg_type) && $stable(msg_addr)); // R6
endmodule

bind dir_ctrl dir_ctrl_chk #(.NCL(NCL), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .msg_valid(msg_valid), .msg_type(msg_type), .msg_dst(msg_dst),
  .msg_addr(msg_addr), .grant(grant)
);

// File: tb/dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ack_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [15:0] req_addr = '0;
  logic [3:0] req_src = '0, ack_src = '0;
  logic req_ready, msg_valid, msg_type, grant;
  logic [3:0] msg_dst;
  logic [15:0] msg_addr;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  dir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_src(req_src),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_dst(msg_dst),
    .msg_addr(msg_addr), .ack_valid(ack_valid), .ack_src(ack_src), .grant(grant)
  );

  // {op, addr, src, expected destination mask, expected type}
  localparam int NV = 15;
  localparam logic [38:0] TBL [NV] = '{
    {2'd0, 16'h0010, 4'd3,  16'h0000, 1'b0},
    {2'd0, 16'h0010, 4'd5,  16'h0008, 1'b1},
    {2'd0, 16'h0010, 4'd9,  16'h0000, 1'b0},
    {2'd1, 16'h0010, 4'd5,  16'h0208, 1'b0},
    {2'd1, 16'h0010, 4'd5,  16'h0000, 1'b0},
    {2'd1, 16'h0010, 4'd0,  16'h0020, 1'b1},
    {2'd0, 16'h0010, 4'd15, 16'h0001, 1'b1},
    {2'd2, 16'h0010, 4'd0,  16'h0000, 1'b0},
    {2'd1, 16'h0010, 4'd15, 16'h0000, 1'b0},
    {2'd2, 16'h0010, 4'd15, 16'h0000, 1'b0},
    {2'd0, 16'h0010, 4'd2,  16'h0000, 1'b0},
    {2'd1, 16'h0020, 4'd1,  16'h0000, 1'b0},
    {2'd0, 16'h0020, 4'd1,  16'h0000, 1'b0},
    {2'd2, 16'h0020, 4'd7,  16'h0000, 1'b0},
    {2'd0, 16'h0020, 4'd4,  16'h0002, 1'b1}
  };
  localparam string TAG [NV] = '{
    "R2 read miss", "R4 read fetch", "R3 read shared", "R5 write inval",
    "R4 owner write", "R4 write fetch", "R4 read fetch", "R8 evict sharer",
    "R5 sole sharer", "R8 evict last", "R8 freed miss", "R2 write miss",
    "R4 owner read", "R8 non-holder", "R8 R4 still excl"
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [15:0] a, input logic [3:0] s,
                        input logic [15:0] em, input logic et, input string tag);
    logic [15:0] got;
    logic gt;
    int last;
    bit gr, ordok;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_src = s;
    #1;
    chk(req_ready === 1'b1, {tag, " ready"}, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    got = '0; gt = et; last = -1; gr = 0; ordok = 1;
    for (int c = 0; c < 100 && !gr; c++) begin
      if (msg_valid) begin
        if (int'(msg_dst) <= last || msg_addr != a) ordok = 0;
        last = int'(msg_dst);
        got[msg_dst] = 1'b1;
        gt = msg_type;
        ack_valid = 1'b1; ack_src = msg_dst;
      end else ack_valid = 1'b0;
      if (grant) gr = 1;
      else @(negedge clk);
    end
    ack_valid = 1'b0;
    chk(gr, {tag, " grant"}, gr, 1);
    chk(got == em, {tag, " destinations"}, got, em);
    chk(em == 0 || gt == et, {tag, " type"}, gt, et);
    chk(ordok, {tag, " R6 order/addr"}, ordok, 1);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
    chk(msg_valid === 1'b0, "R1 reset msg", msg_valid, 0);
    chk(grant === 1'b0, "R1 reset grant", grant, 0);

    for (int i = 0; i < NV; i++)
      do_req(TBL[i][38:37], TBL[i][36:21], TBL[i][20:17], TBL[i][16:1], TBL[i][0], TAG[i]);

    // two records live; fill the remaining six
    for (int i = 0; i < 6; i++)
      do_req(2'd0, 16'h0100 + 16'(i), 4'd0, 16'h0000, 1'b0, "R2 fill");

    // R9: full directory refuses a new miss
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 16'h0200; req_src = 4'd0;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(req_ready === 1'b0, "R9 full refuses", req_ready, 0);
      chk(grant === 1'b0, "R9 full no grant", grant, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    do_req(2'd2, 16'h0200, 4'd0, 16'h0000, 1'b0, "R9 evict miss when full");

    // R7: write to line 0x20 (shared by 1 and 4) from 6, acks withheld
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0020; req_src = 4'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk(msg_valid && msg_dst == 4'd1 && !msg_type, "R5 R7 first inval", msg_dst, 1);
    @(negedge clk);
    chk(msg_valid && msg_dst == 4'd4 && !msg_type, "R5 R6 second inval", msg_dst, 4);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(!grant && !req_ready && !msg_valid, "R7 held without acks", grant, 0);
    end
    ack_valid = 1'b1; ack_src = 4'd9;
    @(negedge clk); ack_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!grant, "R7 stray ack ignored", grant, 0);
    end
    ack_valid = 1'b1; ack_src = 4'd1;
    @(negedge clk); ack_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!grant && !req_ready, "R7 partial acks hold", grant, 0);
    end
    ack_valid = 1'b1; ack_src = 4'd4;
    @(negedge clk); ack_valid = 1'b0;
    @(negedge clk);
    chk(grant === 1'b1, "R7 grant after last ack", grant, 1);
    @(negedge clk);
    chk(grant === 1'b0 && req_ready === 1'b1, "R10 grant pulse", grant, 0);
    do_req(2'd0, 16'h0020, 4'd2, 16'h0040, 1'b1, "R5 writer now owner");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule